// File: doc/BRIEF.md
# Sequential-Read Serial Status Slave

This block is a read-only slave on a two-wire serial bus (SCL clock, open-drain SDA). It oversamples both bus lines with the system clock and detects START and STOP conditions. It compares the first byte after a START with a fixed select code. When the code matches, it streams bytes from a small status register file. Each stream begins at address 0, with no address phase. The address advances after every byte for as long as the master acknowledges.

The register file holds these bytes in this order: a status byte, the previous input-port value, the current input-port value, then `N_WATCH` time-of-day bytes. One address past the last data byte returns a marker byte whose two top bits are zero. After the marker, the address wraps to 0.

The slave only takes part in traffic while `run_mode_i` is high. When the master acknowledges the current-input byte, the block emits a one-cycle `read_done_o` strobe. A mode controller uses this strobe to clear its pending-change indication.

Top module: `ssr_status_slave`

## Requirements
- R1: While run mode is high, a select byte equal to `SEL_CODE` (default 8'h48, received MSB first) is acknowledged: the slave pulls SDA low during the ninth clock.
- R2: A select byte other than `SEL_CODE` is not acknowledged, and SDA stays released (reads as all ones) until the next START.
- R3: After a matching select, bytes are sent MSB first starting at address 0, and the address rises by one after each acknowledged byte. The address map is: 0 status, 1 previous input, 2 current input, 3+k watch byte k = `watch_i[8k+7:8k]`.
- R4: The address just past the last watch byte (8 by default) returns 8'h3F (two top bits zero). The next byte comes from address 0 again.
- R5: Every matching select restarts the stream at address 0, whatever address the previous transfer reached.
- R6: When the master does not acknowledge a byte, the slave releases SDA and keeps it released until the next START or STOP.
- R7: While run mode is low, no select is acknowledged, and SDA is released no later than one clock after run mode falls.
- R8: While run mode stays high, the SDA drive level changes only while SCL is low.
- R9: `read_done_o` pulses for exactly one clock each time the master acknowledges the byte at address 2, and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_mode_i | input | 1 | High while the system is in run mode |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| status_i | input | 8 | Status byte (address 0) |
| old_in_i | input | 8 | Previous input-port value (address 1) |
| new_in_i | input | 8 | Current input-port value (address 2) |
| watch_i | input | 8*N_WATCH | Time-of-day bytes, byte k at bits 8k+7:8k |
| sda_pull_low_o | output | 1 | Open-drain enable: 1 pulls SDA low |
| read_done_o | output | 1 | One-cycle strobe when address 2 is acknowledged |

## Verification
Some properties are checked by assertions on every cycle: the release of SDA after run mode falls, drive changes only while SCL is low, the address staying within the marker address, and `read_done_o` never lasting longer than one cycle. Other behaviour is only visible at the bus pins, so the bench's scenarios must show it. This covers the byte order, the marker byte and the wrap, the restart at address 0 on each select, the missing acknowledge for a wrong select, the released line after a master NACK, and the exact number of strobes per transfer.

// File: rtl/ssr_pkg.sv
package ssr_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEL,
        ST_SEL_ACK,
        ST_SEND,
        ST_MACK,
        ST_HOLD
    } ssr_state_e;

    localparam logic [5:0] MARKER_LOW = 6'h3F;
endpackage

// File: rtl/ssr_line_sync.sv
module ssr_line_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s_o,
    output logic sda_s_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    typedef struct packed {
        logic scl_m;
        logic scl_s;
        logic scl_p;
        logic sda_m;
        logic sda_s;
        logic sda_p;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d       = sync_q;
        sync_d.scl_m = scl_i;
        sync_d.scl_s = sync_q.scl_m;
        sync_d.scl_p = sync_q.scl_s;
        sync_d.sda_m = sda_i;
        sync_d.sda_s = sync_q.sda_m;
        sync_d.sda_p = sync_q.sda_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= sync_d;
    end

    assign scl_s_o    = sync_q.scl_s;
    assign sda_s_o    = sync_q.sda_s;
    assign scl_rise_o = sync_q.scl_s & ~sync_q.scl_p;
    assign scl_fall_o = ~sync_q.scl_s & sync_q.scl_p;
    assign start_o    = sync_q.scl_s & sync_q.scl_p & sync_q.sda_p & ~sync_q.sda_s;
    assign stop_o     = sync_q.scl_s & sync_q.scl_p & ~sync_q.sda_p & sync_q.sda_s;
endmodule

// File: rtl/ssr_byte_mux.sv
module ssr_byte_mux #(
    parameter int N_WATCH = 5,
    localparam int N_DATA = 3 + N_WATCH,
    localparam int AW     = $clog2(N_DATA + 1)
) (
    input  logic [7:0]           status_i,
    input  logic [7:0]           old_in_i,
    input  logic [7:0]           new_in_i,
    input  logic [8*N_WATCH-1:0] watch_i,
    input  logic [AW-1:0]        addr_i,
    output logic [7:0]           byte_o
);
    logic [7:0] bank [N_DATA+1];

    assign bank[0] = status_i;
    assign bank[1] = old_in_i;
    assign bank[2] = new_in_i;

    for (genvar g = 0; g < N_WATCH; g++) begin : g_watch
        assign bank[3+g] = watch_i[8*g +: 8];
    end

    assign bank[N_DATA] = {2'b00, ssr_pkg::MARKER_LOW};

    always_comb begin
        byte_o = 8'h00;
        for (int i = 0; i <= N_DATA; i++) begin
            if (addr_i == AW'(i)) byte_o = bank[i];
        end
    end
endmodule

// File: rtl/ssr_engine.sv
module ssr_engine #(
    parameter logic [7:0] SEL_CODE = 8'h48,
    parameter int N_WATCH = 5,
    localparam int N_DATA = 3 + N_WATCH,
    localparam int AW     = $clog2(N_DATA + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_mode_i,
    input  logic          scl_s_i,
    input  logic          sda_s_i,
    input  logic          scl_rise_i,
    input  logic          scl_fall_i,
    input  logic          start_i,
    input  logic          stop_i,
    input  logic [7:0]    byte_i,
    output logic [AW-1:0] load_addr_o,
    output logic          sda_pull_low_o,
    output logic          read_done_o
);
    import ssr_pkg::*;

    localparam logic [AW-1:0] LAST_ADDR = AW'(N_DATA);
    localparam logic [AW-1:0] NEW_ADDR  = AW'(2);

    typedef struct packed {
        ssr_state_e    state;
        logic [3:0]    bits;
        logic [7:0]    shreg;
        logic [AW-1:0] addr;
        logic          ack;
        logic          done;
    } eng_t;

    eng_t eng_d, eng_q;

    always_comb begin
        if (eng_q.state == ST_SEL_ACK)  load_addr_o = '0;
        else if (eng_q.addr == LAST_ADDR) load_addr_o = '0;
        else                            load_addr_o = eng_q.addr + AW'(1);
    end

    always_comb begin
        eng_d      = eng_q;
        eng_d.done = 1'b0;
        if (!run_mode_i) begin
            eng_d.state = ST_IDLE;
        end else if (start_i) begin
            eng_d.state = ST_SEL;
            eng_d.bits  = '0;
        end else if (stop_i) begin
            eng_d.state = ST_IDLE;
        end else begin
            unique case (eng_q.state)
                ST_SEL: begin
                    if (scl_rise_i) begin
                        eng_d.shreg = {eng_q.shreg[6:0], sda_s_i};
                        eng_d.bits  = eng_q.bits + 4'd1;
                    end else if (scl_fall_i && eng_q.bits == 4'd8) begin
                        eng_d.state = (eng_q.shreg == SEL_CODE) ? ST_SEL_ACK : ST_HOLD;
                    end
                end
                ST_SEL_ACK, ST_MACK: begin
                    if (eng_q.state == ST_MACK && scl_rise_i) begin
                        eng_d.ack  = ~sda_s_i;
                        eng_d.done = ~sda_s_i && (eng_q.addr == NEW_ADDR);
                    end
                    if (scl_fall_i) begin
                        if (eng_q.state == ST_SEL_ACK || eng_q.ack) begin
                            eng_d.state = ST_SEND;
                            eng_d.shreg = byte_i;
                            eng_d.addr  = load_addr_o;
                            eng_d.bits  = '0;
                        end else begin
                            eng_d.state = ST_HOLD;
                        end
                    end
                end
                ST_SEND: begin
                    if (scl_rise_i) begin
                        eng_d.bits = eng_q.bits + 4'd1;
                    end else if (scl_fall_i) begin
                        if (eng_q.bits == 4'd8) begin
                            eng_d.state = ST_MACK;
                            eng_d.ack   = 1'b0;
                        end else begin
                            eng_d.shreg = {eng_q.shreg[6:0], 1'b0};
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_q       <= '0;
            eng_q.state <= ST_IDLE;
        end else begin
            eng_q <= eng_d;
        end
    end

    assign sda_pull_low_o = (eng_q.state == ST_SEL_ACK) ||
                            (eng_q.state == ST_SEND && !eng_q.shreg[7]);
    assign read_done_o    = eng_q.done;

    a_r7_release_off_run: assert property (@(posedge clk) disable iff (!rst_n)
        !run_mode_i |=> !sda_pull_low_o);

    a_r8_change_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        (run_mode_i && $past(run_mode_i) && (sda_pull_low_o != $past(sda_pull_low_o)))
        |-> !scl_s_i);

    a_r4_addr_bound: assert property (@(posedge clk) disable iff (!rst_n)
        eng_q.addr <= LAST_ADDR);

    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        read_done_o |=> !read_done_o);

    a_r9_done_in_run: assert property (@(posedge clk) disable iff (!rst_n)
        read_done_o |-> $past(run_mode_i));
endmodule

// File: rtl/ssr_status_slave.sv
module ssr_status_slave #(
    parameter logic [7:0] SEL_CODE = 8'h48,
    parameter int N_WATCH = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 run_mode_i,
    input  logic                 scl_i,
    input  logic                 sda_i,
    input  logic [7:0]           status_i,
    input  logic [7:0]           old_in_i,
    input  logic [7:0]           new_in_i,
    input  logic [8*N_WATCH-1:0] watch_i,
    output logic                 sda_pull_low_o,
    output logic                 read_done_o
);
    localparam int N_DATA = 3 + N_WATCH;
    localparam int AW     = $clog2(N_DATA + 1);

    logic          scl_s, sda_s, scl_rise, scl_fall, start, stop;
    logic [AW-1:0] load_addr;
    logic [7:0]    load_byte;

    ssr_line_sync i_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_s_o    (scl_s),
        .sda_s_o    (sda_s),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start),
        .stop_o     (stop)
    );

    ssr_byte_mux #(.N_WATCH(N_WATCH)) i_mux (
        .status_i (status_i),
        .old_in_i (old_in_i),
        .new_in_i (new_in_i),
        .watch_i  (watch_i),
        .addr_i   (load_addr),
        .byte_o   (load_byte)
    );

    ssr_engine #(.SEL_CODE(SEL_CODE), .N_WATCH(N_WATCH)) i_engine (
        .clk            (clk),
        .rst_n          (rst_n),
        .run_mode_i     (run_mode_i),
        .scl_s_i        (scl_s),
        .sda_s_i        (sda_s),
        .scl_rise_i     (scl_rise),
        .scl_fall_i     (scl_fall),
        .start_i        (start),
        .stop_i         (stop),
        .byte_i         (load_byte),
        .load_addr_o    (load_addr),
        .sda_pull_low_o (sda_pull_low_o),
        .read_done_o    (read_done_o)
    );
endmodule

// File: tb/test_ssr_status_slave.sv
module test_ssr_status_slave;
    localparam int N_WATCH = 5;
    localparam int Q = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run_mode = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic [7:0] status_v = 8'h00, old_v = 8'h00, new_v = 8'h00;
    logic [8*N_WATCH-1:0] watch_v = '0;
    logic sda_pull_low, read_done;
    wire  sda_line = sda_m & ~sda_pull_low;

    int checks = 0, errors = 0, done_cnt = 0, r8_viol = 0;
    logic prev_low = 1'b0, prev_run = 1'b0;

    always #5 clk = ~clk;

    ssr_status_slave #(.SEL_CODE(8'h48), .N_WATCH(N_WATCH)) i_ssr_status_slave (
        .clk(clk), .rst_n(rst_n), .run_mode_i(run_mode), .scl_i(scl_m), .sda_i(sda_line),
        .status_i(status_v), .old_in_i(old_v), .new_in_i(new_v), .watch_i(watch_v),
        .sda_pull_low_o(sda_pull_low), .read_done_o(read_done)
    );

    // R9 strobe counter and R8 drive-change monitor
    always @(negedge clk) begin
        if (read_done) done_cnt++;
        if (rst_n && run_mode && prev_run && sda_pull_low != prev_low && scl_m) r8_viol++;
        prev_low = sda_pull_low;
        prev_run = run_mode;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_byte(input int idx);
        if (idx == 0) return status_v;
        if (idx == 1) return old_v;
        if (idx == 2) return new_v;
        if (idx < 3 + N_WATCH) return watch_v[8*(idx-3) +: 8];
        return 8'h3F;
    endfunction

    task automatic qw(input int n);
        repeat (n * Q) @(negedge clk);
    endtask

    task automatic bus_start;
        sda_m = 1'b1; qw(1); scl_m = 1'b1; qw(1); sda_m = 1'b0; qw(1); scl_m = 1'b0; qw(1);
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; qw(1); scl_m = 1'b1; qw(1); sda_m = 1'b1; qw(1);
    endtask

    task automatic put_bit(input logic b);
        sda_m = b; qw(1); scl_m = 1'b1; qw(2); scl_m = 1'b0; qw(1);
    endtask

    task automatic get_bit(output logic b);
        sda_m = 1'b1; qw(1); scl_m = 1'b1; qw(1); b = sda_line; qw(1); scl_m = 1'b0; qw(1);
    endtask

    task automatic send_byte(input logic [7:0] v, output bit acked);
        logic a;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(a);
        acked = !a;
    endtask

    task automatic recv_byte(output logic [7:0] v, input bit mack);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
        put_bit(!mack);
    endtask

    // Select, then read n bytes (last one NACKed); checks R1, R3, R4, R5, R9
    task automatic read_seq(input int n);
        bit acked;
        logic [7:0] v;
        int d0, exp_done;
        d0 = done_cnt;
        exp_done = 0;
        bus_start;
        send_byte(8'h48, acked);
        check(acked, "R1 select ack", int'(acked), 1);
        for (int k = 0; k < n; k++) begin
            recv_byte(v, k < n - 1);
            if (k < n - 1 && k % 9 == 2) exp_done++;
            if (k % 9 == 8) check(v == exp_byte(8), "R4 marker/wrap", v, exp_byte(8));
            else if (k == 0) check(v == exp_byte(0), "R5 restart at 0", v, exp_byte(0));
            else check(v == exp_byte(k % 9), "R3 byte order", v, exp_byte(k % 9));
        end
        bus_stop;
        check(done_cnt - d0 == exp_done, "R9 strobe count", done_cnt - d0, exp_done);
    endtask

    task automatic randomize_data;
        status_v = 8'($urandom); old_v = 8'($urandom); new_v = 8'($urandom);
        for (int i = 0; i < N_WATCH; i++) watch_v[8*i +: 8] = 8'($urandom);
    endtask

    initial begin
        bit acked;
        logic [7:0] v;
        int seed;
        seed = $urandom(32'd20240117);
        repeat (3) @(negedge clk);
        check(sda_pull_low == 1'b0, "R6 reset released", sda_pull_low, 0);
        check(read_done == 1'b0, "R9 reset strobe low", read_done, 0);
        rst_n = 1'b1;
        run_mode = 1'b1;
        qw(2);

        // Directed: full stream, marker and wrap (R4), then partial reads
        status_v = 8'hA5; old_v = 8'h3C; new_v = 8'hC3;
        watch_v = 40'h8877665544;
        read_seq(11);
        read_seq(2);   // NACK on byte 1: no strobe
        read_seq(3);   // NACK on byte 2: no strobe (R9)
        read_seq(4);   // byte 2 acked: one strobe (R9)

        // R2: wrong select not acked, line released
        bus_start;
        send_byte(8'h4A, acked);
        check(!acked, "R2 no ack on mismatch", int'(acked), 0);
        recv_byte(v, 1'b0);
        check(v == 8'hFF, "R2 released after mismatch", v, 8'hFF);
        bus_stop;

        // R6: after master NACK the slave stays off the line
        bus_start;
        send_byte(8'h48, acked);
        recv_byte(v, 1'b0);
        check(v == exp_byte(0), "R3 first byte", v, exp_byte(0));
        recv_byte(v, 1'b0);
        check(v == 8'hFF, "R6 released after nack", v, 8'hFF);
        bus_stop;

        // R7: no ack outside run mode
        run_mode = 1'b0;
        bus_start;
        send_byte(8'h48, acked);
        check(!acked, "R7 no ack off run", int'(acked), 0);
        bus_stop;
        run_mode = 1'b1;
        qw(1);

        // R7: release within a clock when run mode drops while driving
        status_v = 8'h00;
        bus_start;
        send_byte(8'h48, acked);
        check(sda_pull_low == 1'b1, "R3 msb driven", sda_pull_low, 1);
        run_mode = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(sda_pull_low == 1'b0, "R7 release on run drop", sda_pull_low, 0);
        run_mode = 1'b1;
        bus_stop;

        // Random mix of transfers and wrong selects
        for (int t = 0; t < 18; t++) begin
            randomize_data;
            if ($urandom_range(4) == 0) begin
                logic [7:0] sel;
                sel = 8'($urandom);
                if (sel == 8'h48) sel = 8'h49;
                bus_start;
                send_byte(sel, acked);
                check(!acked, "R2 random mismatch", int'(acked), 0);
                bus_stop;
            end else begin
                read_seq(1 + int'($urandom_range(11)));
            end
        end

        check(r8_viol == 0, "R8 drive change while SCL high", r8_viol, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule